// File: doc/BRIEF.md
# Animation Frame Sequencer with Timed Hold

The sequencer selects which stored bitmap a graphic display shows and produces the read address into the picture memory for that bitmap. The memory holds sixteen 64x64 frames, but only frames 0 through 8 carry images. The sequencer plays those nine in rising order, one step per frame-advance tick from an external divider. After frame 8 it does not wrap at once. It enters a dedicated hold state, runs its own pause counter for two seconds while frame 8 stays on screen, and then restarts at frame 0.

Inside the current frame, a pixel offset scans the 64x64 bitmap in row-major order, one pixel per clock. The offset restarts at zero whenever a new frame takes effect. The memory address is the frame index in the upper four bits joined to the 12-bit pixel offset. A one-cycle strobe marks every frame change, so a display controller can line up its refresh with the new picture. The hold length is worked out from the clock frequency, which lets a bench shorten it by giving a small frequency.

Top module: `anim_seq`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the next cycle shows `frame_idx` = 0, `pix_off` = 0 and `frame_start` = 0. The sequencer is then in the play state with its pause counter cleared.
- R2: In the play state, when `adv_tick` is sampled high and `frame_idx` is below 8, the next cycle shows `frame_idx` one higher.
- R3: `frame_idx` never takes any value from 9 to 15.
- R4: In the play state, when `adv_tick` is sampled high with `frame_idx` = 8, the sequencer enters the hold state. In the next cycle `frame_idx` is still 8 and `frame_start` is 0.
- R5: The hold state lasts exactly `PAUSE_CYCLES` clock cycles. In the cycle after that, `frame_idx` is 0 and `frame_start` is 1.
- R6: `adv_tick` has no effect in the hold state. `frame_idx` stays 8, and the time spent in the hold state does not change.
- R7: `frame_start` is 1 for exactly the cycles in which a new frame index takes effect, including the return to frame 0 after the hold. It is 0 in every other cycle.
- R8: `pix_off` rises by one every clock cycle and wraps from 4095 to 0. In any cycle where `frame_start` is 1, `pix_off` is 0 instead. It keeps scanning during the hold state.
- R9: `rom_addr` equals `frame_idx` in bits 15:12 joined with `pix_off` in bits 11:0.
- R10: By default, `PAUSE_CYCLES` equals `CLK_HZ` multiplied by `PAUSE_SEC`, which defaults to 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_tick | input | 1 | Frame-advance tick from an external divider, one cycle wide |
| frame_idx | output | 4 | Index of the frame currently shown |
| pix_off | output | 12 | Row-major pixel offset inside the current frame |
| rom_addr | output | 16 | Picture memory read address |
| frame_start | output | 1 | One-cycle strobe when a new frame index takes effect |

## Verification
Every output is registered once. The result of an input sampled at one edge appears in the cycle that starts at that edge: a tick moves `frame_idx` and raises `frame_start` in the next cycle, and the pixel offset steps on every edge. The bench changes inputs only at falling edges. At each following falling edge it compares all outputs against a cycle model written from the requirements. It uses a frequency of 18 Hz, so the default formula gives a 36-cycle hold. The directed passes rely on this. They place ticks on the exact edge that enters the hold and on every cycle inside it. They also let a frame run untouched past the 4095-to-0 wrap.

// File: rtl/anim_pkg.sv
package anim_pkg;

    // Sequencer control state
    typedef enum logic [0:0] {
        ST_PLAY  = 1'b0,
        ST_PAUSE = 1'b1
    } seq_state_e;

endpackage

// File: rtl/anim_pixel_scan.sv
// Row-major pixel scanner across one frame; restart forces offset 0.
module anim_pixel_scan #(
    parameter int FRAME_W = 64,
    parameter int FRAME_H = 64,
    localparam int COL_W  = $clog2(FRAME_W),
    localparam int ROW_W  = $clog2(FRAME_H),
    localparam int PIX_W  = $clog2(FRAME_W * FRAME_H)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic [PIX_W-1:0] pix_off
);

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
    } scan_t;

    scan_t scan_d, scan_q;

    localparam logic [COL_W-1:0] COL_LAST = COL_W'(FRAME_W - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(FRAME_H - 1);

    always_comb begin
        scan_d = scan_q;
        if (restart) begin
            scan_d.col = '0;
            scan_d.row = '0;
        end else if (scan_q.col == COL_LAST) begin
            scan_d.col = '0;
            scan_d.row = (scan_q.row == ROW_LAST) ? '0 : scan_q.row + 1'b1;
        end else begin
            scan_d.col = scan_q.col + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scan_q <= '0;
        end else begin
            scan_q <= scan_d;
        end
    end

    // Power-of-two width joins row and column; other widths multiply out.
    generate
        if ((1 << COL_W) == FRAME_W && (1 << ROW_W) == FRAME_H) begin : g_concat
            assign pix_off = PIX_W'({scan_q.row, scan_q.col});
        end else begin : g_mult
            assign pix_off = PIX_W'(PIX_W'(scan_q.row) * PIX_W'(FRAME_W))
                           + PIX_W'(scan_q.col);
        end
    endgenerate

endmodule

// File: rtl/anim_pause_timer.sv
// Counts cycles while run is high; done flags the last cycle of the hold.
module anim_pause_timer #(
    parameter int PAUSE_CYCLES = 500_000_000,
    localparam int CNT_W       = $clog2(PAUSE_CYCLES) + 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PAUSE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign done = run && (cnt_q == CNT_LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (!done) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/anim_seq.sv
// Frame sequencer: plays the image-bearing frames, then holds before wrapping.
module anim_seq #(
    parameter int CLK_HZ       = 250_000_000,
    parameter int PAUSE_SEC    = 2,
    parameter int PAUSE_CYCLES = CLK_HZ * PAUSE_SEC,
    parameter int NUM_FRAMES   = 16,
    parameter int PLAY_FRAMES  = 9,
    parameter int FRAME_W      = 64,
    parameter int FRAME_H      = 64,
    localparam int FIDX_W      = $clog2(NUM_FRAMES),
    localparam int PIX_W       = $clog2(FRAME_W * FRAME_H),
    localparam int ADDR_W      = FIDX_W + PIX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_tick,
    output logic [FIDX_W-1:0] frame_idx,
    output logic [PIX_W-1:0]  pix_off,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              frame_start
);

    import anim_pkg::*;

    localparam logic [FIDX_W-1:0] LAST_FRAME = FIDX_W'(PLAY_FRAMES - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [FIDX_W-1:0] frame;
        logic              fstart;
    } seq_t;

    seq_t seq_d, seq_q;
    logic in_pause;
    logic pause_done;

    assign in_pause = (seq_q.state == ST_PAUSE);

    anim_pause_timer #(
        .PAUSE_CYCLES (PAUSE_CYCLES)
    ) timer_i (
        .clk  (clk),
        .rst  (rst),
        .run  (in_pause),
        .done (pause_done)
    );

    always_comb begin
        seq_d        = seq_q;
        seq_d.fstart = 1'b0;
        unique case (seq_q.state)
            ST_PLAY: begin
                if (adv_tick) begin
                    if (seq_q.frame == LAST_FRAME) begin
                        seq_d.state = ST_PAUSE;
                    end else begin
                        seq_d.frame  = seq_q.frame + 1'b1;
                        seq_d.fstart = 1'b1;
                    end
                end
            end
            ST_PAUSE: begin
                if (pause_done) begin
                    seq_d.state  = ST_PLAY;
                    seq_d.frame  = '0;
                    seq_d.fstart = 1'b1;
                end
            end
            default: seq_d.state = ST_PLAY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '{state: ST_PLAY, frame: '0, fstart: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    anim_pixel_scan #(
        .FRAME_W (FRAME_W),
        .FRAME_H (FRAME_H)
    ) scan_i (
        .clk     (clk),
        .rst     (rst),
        .restart (seq_d.fstart),
        .pix_off (pix_off)
    );

    assign frame_idx   = seq_q.frame;
    assign frame_start = seq_q.fstart;
    assign rom_addr    = {seq_q.frame, pix_off};

endmodule

// File: rtl/anim_seq_chk.sv
// Property checker attached to anim_seq.
module anim_seq_chk #(
    parameter int FIDX_W = 4,
    parameter int PIX_W  = 12,
    parameter int LAST_F = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              adv_tick,
    input logic              in_pause,
    input logic              pause_done,
    input logic [FIDX_W-1:0] frame_idx,
    input logic [PIX_W-1:0]  pix_off,
    input logic              frame_start
);

    localparam logic [FIDX_W-1:0] LAST_V = FIDX_W'(LAST_F);

    // R1
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (frame_idx == '0 && pix_off == '0 && !frame_start));

    // R3
    p_frame_range_r3: assert property (@(posedge clk) disable iff (rst)
        frame_idx <= LAST_V);

    // R4
    p_enter_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!in_pause && adv_tick && frame_idx == LAST_V)
            |=> (frame_idx == LAST_V && !frame_start && in_pause));

    // R6
    p_hold_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (in_pause && !pause_done) |=> ($stable(frame_idx) && !frame_start));

    // R5
    p_hold_exit_r5: assert property (@(posedge clk) disable iff (rst)
        (in_pause && pause_done) |=> (frame_idx == '0 && frame_start));

    // R7
    p_start_on_change_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && frame_idx != $past(frame_idx)) |-> frame_start);

    // R8
    p_pix_step_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !frame_start) |-> (pix_off == PIX_W'($past(pix_off) + 1'b1)));

    // R8
    p_pix_restart_r8: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (pix_off == '0));

endmodule

bind anim_seq anim_seq_chk #(
    .FIDX_W (FIDX_W),
    .PIX_W  (PIX_W),
    .LAST_F (PLAY_FRAMES - 1)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .adv_tick    (adv_tick),
    .in_pause    (in_pause),
    .pause_done  (pause_done),
    .frame_idx   (frame_idx),
    .pix_off     (pix_off),
    .frame_start (frame_start)
);

// File: tb/anim_seq_tb_top.sv
module anim_seq_tb_top;

    localparam int TB_CLK_HZ = 18;
    localparam int HOLD      = 2 * TB_CLK_HZ;   // R10 default formula
    localparam int LASTF     = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adv_tick = 1'b0;
    logic [3:0]  frame_idx;
    logic [11:0] pix_off;
    logic [15:0] rom_addr;
    logic        frame_start;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Reference model state
    bit         m_pause = 1'b0;
    logic [3:0] m_frame = '0;
    logic [11:0] m_pix  = '0;
    int         m_cnt   = 0;
    bit         m_fs    = 1'b0;
    string      m_tag   = "R1";
    int         pause_len = 0;

    always #2 clk = ~clk;

    anim_seq #(
        .CLK_HZ (TB_CLK_HZ)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .adv_tick    (adv_tick),
        .frame_idx   (frame_idx),
        .pix_off     (pix_off),
        .rom_addr    (rom_addr),
        .frame_start (frame_start)
    );

    task automatic check(input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_addr(input logic [3:0] f, input logic [11:0] p);
        return {f, p};
    endfunction

    // Advance the model by one clock edge, from the requirements.
    task automatic model_step(input bit t, input bit r);
        if (r) begin
            m_pause = 1'b0; m_frame = '0; m_pix = '0; m_cnt = 0; m_fs = 1'b0;
            m_tag = "R1";
        end else if (!m_pause) begin
            if (t && m_frame == 4'(LASTF)) begin
                m_pause = 1'b1; m_cnt = 0; m_fs = 1'b0; m_pix = m_pix + 1'b1;
                m_tag = "R4";
            end else if (t) begin
                m_frame = m_frame + 1'b1; m_fs = 1'b1; m_pix = '0;
                m_tag = "R2";
            end else begin
                m_fs = 1'b0; m_pix = m_pix + 1'b1;
                m_tag = "R2";
            end
        end else begin
            if (m_cnt == HOLD - 1) begin
                m_pause = 1'b0; m_frame = '0; m_fs = 1'b1; m_pix = '0;
                m_tag = "R5 R10";
            end else begin
                m_cnt++; m_fs = 1'b0; m_pix = m_pix + 1'b1;
                m_tag = t ? "R6" : "R5";
            end
        end
    endtask

    task automatic step(input bit t, input bit r);
        adv_tick = t;
        rst      = r;
        model_step(t, r);
        @(negedge clk);
        check(m_tag, "frame_idx", int'(frame_idx), int'(m_frame));
        check("R7", "frame_start", int'(frame_start), int'(m_fs));
        check("R8", "pix_off", int'(pix_off), int'(m_pix));
        check("R9", "rom_addr", int'(rom_addr), int'(exp_addr(m_frame, m_pix)));
        check("R3", "frame_idx<=8", int'(frame_idx <= 4'(LASTF)), 1);
    endtask

    initial begin
        int seed;
        seed = 32'h5eed_a11e;
        void'($urandom(seed));

        // R1: reset state
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1);

        // Random play with sparse ticks
        for (int i = 0; i < 2500; i++) step(($urandom % 5) == 0, 1'b0);

        // Back-to-back ticks across a full loop
        for (int i = 0; i < 60; i++) step(1'b1, 1'b0);

        // R4/R6: reach frame 8, enter hold, tick every cycle inside it
        while (m_pause) step(1'b0, 1'b0);
        while (m_frame != 4'(LASTF)) step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        pause_len = 0;
        while (m_pause) begin
            step(1'b1, 1'b0);
            pause_len++;
        end
        // R5 R10: hold spans HOLD cycles after entry edge
        check("R5 R10", "hold length", pause_len, HOLD);

        // R8: let one frame run past the pixel wrap
        for (int i = 0; i < 4200; i++) step(1'b0, 1'b0);

        // R1: reset in the middle of a hold
        while (m_frame != 4'(LASTF)) step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);

        // More random traffic with dense ticks
        for (int i = 0; i < 1500; i++) step(($urandom % 2) == 0, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150_000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule